// File: doc/BRIEF.md
# Serial DMA Request Line Decoder (Host Side)

This block sits in a host controller and listens to the single-wire, active-low DMA request line that peripherals use to signal a change in their DMA request state. Each request on the wire is a six-bit serial frame that carries a channel number and a request level. The decoder rebuilds one emulated request level per DMA channel from these frames and presents them as a parallel vector to the host DMA engine. Channel 4 is not an ordinary DMA channel. A frame that names it drives a separate bus-master request flag instead.

The host DMA engine reports every DMA byte it completes on a one-cycle notification: the channel and the 4-bit handshake (SYNC) code the peripheral returned. A ready code (0000) or an error code (1010) drops the emulated request for that channel, and the engine then stops after the following byte. A keep-going code (1001) leaves the request standing, so the peripheral does not need to send another frame. The decoder owns only the request levels. Sequencing of the transfers happens elsewhere.

Top module: `dreq_host_top`

## Requirements
- R1: After reset, all emulated request levels, the bus-master flag and the framing-error pulse are 0.
- R2: A frame is, in sampling order: a start bit 0, three channel bits, one level bit, and a stop bit 1. A level bit of 1 sets the channel's request bit in `drq`. The bit is visible from the clock edge that samples the stop bit.
- R3: A valid frame with level bit 0 clears the channel's request bit, with the same timing as R2.
- R4: The channel number is sent most significant bit first. Bits sampled as 1,1,0 name channel 6, not channel 3.
- R5: When the stop bit is sampled as 0, the frame changes no state. `frame_err` is then high for exactly one cycle, starting from that same edge.
- R6: A valid frame for channel 4 loads its level bit into `bm_req`. `drq[4]` stays 0 at all times.
- R7: A notification with SYNC 0000 or 1010 clears `drq` for the named channel on the next edge and leaves the other channels unchanged.
- R8: A notification with SYNC 1001, or with any code other than 0000 and 1010, leaves `drq` unchanged.
- R9: A notification that names channel 4 has no effect on `bm_req`.
- R10: A start bit may follow a stop bit with no idle cycle between them, and both frames take effect.
- R11: If a valid frame and a clearing or keeping notification name the same channel in the same cycle, the frame's level bit wins.
- R12: While the line stays high, no request level changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_line_n | input | 1 | Serial request line, idles high |
| note_valid | input | 1 | One-cycle DMA byte notification strobe |
| note_chan | input | 3 | Channel of the notified DMA byte |
| note_sync | input | 4 | SYNC code seen in that byte |
| drq | output | 8 | Emulated request level per channel, bit 4 always 0 |
| bm_req | output | 1 | Bus-master request level (channel 4) |
| frame_err | output | 1 | One-cycle pulse on a bad stop bit |

## Verification
The assertions assume that the request line is already synchronous to `clk` and holds one bit for each sampling edge. They also assume that `note_valid` lasts exactly one cycle for each DMA byte, with `note_chan` and `note_sync` stable while it is high. The bench changes every input on the falling edge and raises the strobe for one cycle per notification. It drives frames bit by bit at one bit per clock, so every input it applies falls within these assumptions. The same-channel collision of R11 is the only case in which a frame and a notification overlap on purpose. The assertions leave that case out explicitly, and the directed checks compare the outcome against the rule that the frame wins.

// File: rtl/dreq_pkg.sv
// Package: shared state encoding and SYNC code values for the DMA request
// decoder. Assumes a 4-bit SYNC nibble as reported by the host DMA engine.
package dreq_pkg;
    localparam int SYNC_W = 4;

    localparam logic [SYNC_W-1:0] SYNC_READY = 4'b0000;
    localparam logic [SYNC_W-1:0] SYNC_FAULT = 4'b1010;
    localparam logic [SYNC_W-1:0] SYNC_KEEP  = 4'b1001;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_CHAN,
        RX_LVL,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/dreq_frame_rx.sv
// Module: serial frame receiver. Waits with the line high and takes a low
// sample in idle as the start bit. It then shifts in CHAN_W channel bits
// (MSB first), one level bit and the stop bit. On a good stop bit it raises
// done for that cycle (combinational, qualified by the live line value). On
// a bad stop bit it raises a registered one-cycle error pulse. Assumes the
// line is synchronous to clk and carries one bit per clock.
module dreq_frame_rx
    import dreq_pkg::*;
#(
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_n,
    output logic              done,
    output logic [CHAN_W-1:0] chan,
    output logic              lvl,
    output logic              err
);
    localparam int CNT_W = $clog2(CHAN_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAN_W - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [CHAN_W-1:0] chan_q;
    logic [CHAN_W-1:0] chan_nx;
    logic              lvl_q;
    logic              err_q;

    // Next channel shift value: the sampled bit enters at the LSB.
    always_comb begin
        chan_nx = CHAN_W'(chan_q << 1) | CHAN_W'(line_n);
    end

    // Frame sequencer: walks start, channel bits, level and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            chan_q <= '0;
            lvl_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (!line_n) begin
                        state <= RX_CHAN;
                        cnt   <= '0;
                    end
                end
                RX_CHAN: begin
                    chan_q <= chan_nx;
                    cnt    <= cnt + 1'b1;
                    if (cnt == LAST_BIT) begin
                        state <= RX_LVL;
                    end
                end
                RX_LVL: begin
                    lvl_q <= line_n;
                    state <= RX_STOP;
                end
                RX_STOP: begin
                    err_q <= ~line_n;
                    state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // Frame outputs: commit strobe during a good stop bit.
    always_comb begin
        done = (state == RX_STOP) && line_n;
        chan = chan_q;
        lvl  = lvl_q;
        err  = err_q;
    end
endmodule

// File: rtl/dreq_level_bank.sv
// Module: per-channel emulated request levels. A committed frame loads its
// level into the named channel. A DMA byte notification with a ready or
// fault SYNC clears the named channel. A frame overrides a notification on
// the same channel in the same cycle. The bus-master channel feeds bm_req
// only: its drq bit is tied low, and notifications do not touch it.
// Assumes note_valid is a one-cycle strobe per DMA byte.
module dreq_level_bank
    import dreq_pkg::*;
#(
    parameter int CHAN_W  = 3,
    parameter int BM_CHAN = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set_valid,
    input  logic [CHAN_W-1:0]         set_chan,
    input  logic                      set_lvl,
    input  logic                      note_valid,
    input  logic [CHAN_W-1:0]         note_chan,
    input  logic [SYNC_W-1:0]         note_sync,
    output logic [(1 << CHAN_W)-1:0]  drq,
    output logic                      bm_req
);
    localparam int NCHAN = 1 << CHAN_W;

    logic note_clr;

    // Decode which SYNC codes end the request.
    always_comb begin
        note_clr = note_valid &&
                   ((note_sync == SYNC_READY) || (note_sync == SYNC_FAULT));
    end

    for (genvar g = 0; g < NCHAN; g++) begin : g_lane
        localparam logic [CHAN_W-1:0] IDX = CHAN_W'(g);
        if (g == BM_CHAN) begin : g_bm
            logic bm_q;
            // Bus-master level: loaded only by frames.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bm_q <= 1'b0;
                end else if (set_valid && (set_chan == IDX)) begin
                    bm_q <= set_lvl;
                end
            end
            assign drq[g] = 1'b0;
            assign bm_req = bm_q;
        end else begin : g_dma
            logic lvl_q;
            // DMA lane level: frame wins, otherwise the clearing SYNC applies.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lvl_q <= 1'b0;
                end else if (set_valid && (set_chan == IDX)) begin
                    lvl_q <= set_lvl;
                end else if (note_clr && (note_chan == IDX)) begin
                    lvl_q <= 1'b0;
                end
            end
            assign drq[g] = lvl_q;
        end
    end
endmodule

// File: rtl/dreq_host_top.sv
// Module: top of the host-side DMA request decoder. Joins the serial frame
// receiver to the level bank and brings out the emulated request vector,
// the bus-master flag and the framing-error pulse. Assumes req_line_n is
// already synchronised to clk.
module dreq_host_top
    import dreq_pkg::*;
#(
    parameter int CHAN_W  = 3,
    parameter int BM_CHAN = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_line_n,
    input  logic                     note_valid,
    input  logic [CHAN_W-1:0]        note_chan,
    input  logic [SYNC_W-1:0]        note_sync,
    output logic [(1 << CHAN_W)-1:0] drq,
    output logic                     bm_req,
    output logic                     frame_err
);
    logic              frm_done;
    logic [CHAN_W-1:0] frm_chan;
    logic              frm_lvl;

    dreq_frame_rx #(.CHAN_W(CHAN_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_n (req_line_n),
        .done   (frm_done),
        .chan   (frm_chan),
        .lvl    (frm_lvl),
        .err    (frame_err)
    );

    dreq_level_bank #(.CHAN_W(CHAN_W), .BM_CHAN(BM_CHAN)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_valid  (frm_done),
        .set_chan   (frm_chan),
        .set_lvl    (frm_lvl),
        .note_valid (note_valid),
        .note_chan  (note_chan),
        .note_sync  (note_sync),
        .drq        (drq),
        .bm_req     (bm_req)
    );
endmodule

// File: rtl/dreq_host_chk.sv
// Module: assertion checker for dreq_host_top, attached by bind. It watches
// the receiver-to-bank commit signals and the block outputs.
module dreq_host_chk
    import dreq_pkg::*;
#(
    parameter int CHAN_W  = 3,
    parameter int BM_CHAN = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     note_valid,
    input logic [CHAN_W-1:0]        note_chan,
    input logic [SYNC_W-1:0]        note_sync,
    input logic [(1 << CHAN_W)-1:0] drq,
    input logic                     bm_req,
    input logic                     frame_err,
    input logic                     frm_done,
    input logic [CHAN_W-1:0]        frm_chan,
    input logic                     frm_lvl
);
    localparam logic [CHAN_W-1:0] BM_IDX = CHAN_W'(BM_CHAN);

    logic clr_code;
    assign clr_code = (note_sync == SYNC_READY) || (note_sync == SYNC_FAULT);

    // R2
    frame_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && frm_lvl && (frm_chan != BM_IDX) |=> drq[$past(frm_chan)]);

    // R3
    frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && !frm_lvl && (frm_chan != BM_IDX) |=> !drq[$past(frm_chan)]);

    // R5
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R6
    bm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && (frm_chan == BM_IDX) |=> bm_req == $past(frm_lvl));

    // R7
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        note_valid && clr_code && (note_chan != BM_IDX) &&
        !(frm_done && (frm_chan == note_chan)) |=> !drq[$past(note_chan)]);

    // R8
    sync_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        note_valid && !clr_code && !frm_done |=> $stable(drq));

    // R9
    bm_note_chk: assert property (@(posedge clk) disable iff (!rst_n)
        note_valid && (note_chan == BM_IDX) &&
        !(frm_done && (frm_chan == BM_IDX)) |=> $stable(bm_req));
endmodule

bind dreq_host_top dreq_host_chk #(.CHAN_W(CHAN_W), .BM_CHAN(BM_CHAN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .note_valid (note_valid),
    .note_chan  (note_chan),
    .note_sync  (note_sync),
    .drq        (drq),
    .bm_req     (bm_req),
    .frame_err  (frame_err),
    .frm_done   (frm_done),
    .frm_chan   (frm_chan),
    .frm_lvl    (frm_lvl)
);

// File: tb/sim_dreq_host_top.sv
// Directed bench for dreq_host_top: one task per scenario, each checking
// its own results against a model kept by the bench.
module sim_dreq_host_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_line_n = 1'b1;
    logic       note_valid = 1'b0;
    logic [2:0] note_chan = '0;
    logic [3:0] note_sync = '0;
    logic [7:0] drq;
    logic       bm_req;
    logic       frame_err;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_drq = '0;
    logic       exp_bm = 1'b0;

    always #4 clk = ~clk;

    dreq_host_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_line_n (req_line_n),
        .note_valid (note_valid),
        .note_chan  (note_chan),
        .note_sync  (note_sync),
        .drq        (drq),
        .bm_req     (bm_req),
        .frame_err  (frame_err)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive six frame bits, one per falling edge; the caller ends the frame.
    task automatic send_frame(input logic [2:0] ch, input logic lvl, input logic stopb);
        logic [5:0] bits;
        bits = {1'b0, ch, lvl, stopb};
        for (int i = 5; i >= 0; i--) begin
            @(negedge clk);
            req_line_n = bits[i];
            note_valid = 1'b0;
        end
    endtask

    task automatic idle_tick();
        @(negedge clk);
        req_line_n = 1'b1;
        note_valid = 1'b0;
    endtask

    task automatic notify(input logic [2:0] ch, input logic [3:0] s);
        @(negedge clk);
        note_valid = 1'b1;
        note_chan  = ch;
        note_sync  = s;
        idle_tick();
    endtask

    task automatic frame_ok(input logic [2:0] ch, input logic lvl);
        send_frame(ch, lvl, 1'b1);
        idle_tick();
        if (ch == 3'd4) exp_bm = lvl; else exp_drq[ch] = lvl;
    endtask

    task automatic t_reset();
        chk("R1 drq", drq, 8'h00);
        chk("R1 bm_req", {7'd0, bm_req}, 8'h00);
        chk("R1 frame_err", {7'd0, frame_err}, 8'h00);
    endtask

    task automatic t_idle();
        repeat (20) idle_tick();
        chk("R12 idle line", drq, exp_drq);
    endtask

    task automatic t_set_order();
        frame_ok(3'd6, 1'b1);
        chk("R2/R4 ch6 set msb first", drq, 8'h40);
        frame_ok(3'd1, 1'b1);
        chk("R2/R4 ch1 set", drq, 8'h42);
    endtask

    task automatic t_drop();
        frame_ok(3'd6, 1'b0);
        chk("R3 ch6 cleared", drq, 8'h02);
    endtask

    task automatic t_bad_stop();
        send_frame(3'd3, 1'b1, 1'b0);
        idle_tick();
        chk("R5 err pulse high", {7'd0, frame_err}, 8'h01);
        chk("R5 no state change", drq, exp_drq);
        idle_tick();
        chk("R5 err pulse one cycle", {7'd0, frame_err}, 8'h00);
    endtask

    task automatic t_busmaster();
        frame_ok(3'd4, 1'b1);
        chk("R6 bm_req set", {7'd0, bm_req}, 8'h01);
        chk("R6 drq4 low", drq, exp_drq);
    endtask

    task automatic t_sync_clear();
        frame_ok(3'd0, 1'b1);
        frame_ok(3'd7, 1'b1);
        chk("R2 ch0 ch7 set", drq, 8'h83);
        notify(3'd0, 4'b0000);
        chk("R7 ready clears ch0", drq, 8'h82);
        notify(3'd7, 4'b1010);
        chk("R7 fault clears ch7", drq, 8'h02);
        exp_drq = 8'h02;
    endtask

    task automatic t_sync_keep();
        frame_ok(3'd2, 1'b1);
        notify(3'd2, 4'b1001);
        chk("R8 keep code holds ch2", drq, 8'h06);
        notify(3'd2, 4'b0110);
        chk("R8 other code holds ch2", drq, 8'h06);
    endtask

    task automatic t_bm_note();
        notify(3'd4, 4'b0000);
        chk("R9 note on ch4 ignored", {7'd0, bm_req}, 8'h01);
        frame_ok(3'd4, 1'b0);
        chk("R6 bm_req cleared by frame", {7'd0, bm_req}, 8'h00);
    endtask

    task automatic t_back_to_back();
        send_frame(3'd3, 1'b1, 1'b1);
        send_frame(3'd5, 1'b1, 1'b1);
        idle_tick();
        exp_drq[3] = 1'b1;
        exp_drq[5] = 1'b1;
        chk("R10 back-to-back frames", drq, exp_drq);
    endtask

    task automatic t_collide();
        // Stop bit of a ch3 level-1 frame sampled with a clearing note on ch3.
        send_frame(3'd3, 1'b1, 1'b1);
        note_valid = 1'b1;
        note_chan  = 3'd3;
        note_sync  = 4'b0000;
        idle_tick();
        chk("R11 frame beats clear", drq, exp_drq);
        send_frame(3'd3, 1'b0, 1'b1);
        note_valid = 1'b1;
        note_chan  = 3'd3;
        note_sync  = 4'b1001;
        idle_tick();
        exp_drq[3] = 1'b0;
        chk("R11 frame beats keep", drq, exp_drq);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_idle();
        t_set_order();
        t_drop();
        t_bad_stop();
        t_busmaster();
        t_sync_clear();
        t_sync_keep();
        t_bm_note();
        t_back_to_back();
        t_collide();
        repeat (2) idle_tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule